// File: doc/BRIEF.md
# AXI4-Lite Control Register Slave

This block is a memory-mapped slave holding a small bank of 32-bit control registers. A bus master reaches it over AXI4-Lite. Every access is a single beat, and every access receives exactly one response. The five channels each complete a transfer on a VALID/READY handshake. These channels are write address, write data, write response, read address and read data.

On the write side, the address and the data are captured independently. Either may arrive first, or both may arrive in the same cycle. The register is updated only when both halves are present. The write data carries a byte strobe, and each strobe bit decides whether its byte of the addressed register takes the new value.

Only one write is in flight at a time. The slave stops accepting write address and write data until the pending response has been taken. Reads sample the bank when the read address handshake completes. The read data is returned one cycle later and held until the master accepts it.

An access outside the register window is refused without touching the bank. An access inside the window that is not word aligned is refused in the same way.

Top module: `ctrl_reg_lite`

## Requirements
- R1: After reset, awready, wready and arready are high, bvalid and rvalid are low, and every register reads back as zero.
- R2: A write is accepted when the address handshake comes before, after, or in the same cycle as the data handshake. Each such write produces one response and updates the register.
- R3: Strobe bit n enables wdata bits [8n+7:8n]. A byte whose strobe bit is low keeps its previous value, so an all-zero strobe changes nothing.
- R4: bvalid rises only after both the address handshake and the data handshake of that write have completed.
- R5: Once bvalid is high, bvalid and bresp stay unchanged until a cycle with bready high.
- R6: While bvalid is high, awready and wready are low.
- R7: rvalid rises only in the cycle after a read address handshake. An aligned in-range read returns the register's current value with rresp OKAY (2'b00).
- R8: Once rvalid is high, rvalid, rdata and rresp stay unchanged until a cycle with rready high, and arready is low meanwhile.
- R9: An address at or above 0x20 (byte offset; eight words at offsets 0x00 to 0x1C) gets response DECERR (2'b11). Such a write changes no register, and such a read returns data zero.
- R10: An in-range address whose two low bits are not zero gets response SLVERR (2'b10). Such a write changes no register, and such a read returns data zero.
- R11: The response code EXOKAY (2'b01) never appears on bresp or rresp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous reset, active low |
| awvalid | input | 1 | Write address offered |
| awready | output | 1 | Write address can be taken |
| awaddr | input | ADDR_W | Write byte address |
| wvalid | input | 1 | Write data offered |
| wready | output | 1 | Write data can be taken |
| wdata | input | DATA_W | Write data word |
| wstrb | input | DATA_W/8 | Byte enables for wdata |
| bvalid | output | 1 | Write response present |
| bready | input | 1 | Master takes the write response |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address offered |
| arready | output | 1 | Read address can be taken |
| araddr | input | ADDR_W | Read byte address |
| rvalid | output | 1 | Read data present |
| rready | input | 1 | Master takes the read data |
| rdata | output | DATA_W | Read data word |
| rresp | output | 2 | Read response code |

## Verification
The properties assume a well-behaved master on the inputs. Once awvalid, wvalid or arvalid is raised, it stays high with its payload unchanged until the matching ready has been seen. The response-side readies may toggle freely. The stimulus keeps to this assumption because every channel is driven by a task that raises VALID once, holds the payload and drops VALID only after the handshake cycle. Gaps before each VALID and before each READY are varied, and the addresses deliberately cover the out-of-window and misaligned regions.

// File: rtl/creg_pkg.sv
package creg_pkg;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;

endpackage

// File: rtl/creg_decode.sv
module creg_decode
  import creg_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output resp_e             resp
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];
  assign idx  = word[IDX_W-1:0];

  // out-of-window wins over misalignment
  always_comb begin
    if (word >= WORD_W'(NUM_REGS))   resp = RESP_DECERR;
    else if (addr[1:0] != 2'b00)     resp = RESP_SLVERR;
    else                             resp = RESP_OKAY;
  end
endmodule

// File: rtl/creg_bank.sv
module creg_bank #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int STRB_W  = DATA_W / 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STRB_W-1:0] wr_strb,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] row [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_en && wr_idx == IDX_W'(r)) begin
        for (int b = 0; b < STRB_W; b++) begin
          if (wr_strb[b]) q[8*b +: 8] <= wr_data[8*b +: 8];
        end
      end
    end
    assign row[r] = q;
  end

  assign rd_data = row[rd_idx];
endmodule

// File: rtl/creg_wr_ctrl.sv
module creg_wr_ctrl
  import creg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  output logic              bvalid,
  input  logic              bready,
  output resp_e             bresp,
  output logic              aw_fire,
  output logic              w_fire,
  output logic              commit,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [DATA_W-1:0] cm_data,
  output logic [STRB_W-1:0] cm_strb,
  input  resp_e             cm_resp
);
  logic              aw_held, w_held;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;

  assign awready = !aw_held && !bvalid;
  assign wready  = !w_held && !bvalid;
  assign aw_fire = awvalid && awready;
  assign w_fire  = wvalid && wready;
  assign commit  = (aw_held || aw_fire) && (w_held || w_fire) && !bvalid;

  assign cm_addr = aw_held ? addr_q : awaddr;
  assign cm_data = w_held ? data_q : wdata;
  assign cm_strb = w_held ? strb_q : wstrb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_held <= 1'b0;
      w_held  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      strb_q  <= '0;
      bvalid  <= 1'b0;
      bresp   <= RESP_OKAY;
    end else begin
      if (commit) begin
        aw_held <= 1'b0;
      end else if (aw_fire) begin
        aw_held <= 1'b1;
        addr_q  <= awaddr;
      end
      if (commit) begin
        w_held <= 1'b0;
      end else if (w_fire) begin
        w_held <= 1'b1;
        data_q <= wdata;
        strb_q <= wstrb;
      end
      if (commit) begin
        bvalid <= 1'b1;
        bresp  <= cm_resp;
      end else if (bready) begin
        bvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/creg_rd_ctrl.sv
module creg_rd_ctrl
  import creg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arvalid,
  output logic              arready,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output resp_e             rresp,
  output logic              ar_fire,
  input  resp_e             ar_resp,
  input  logic [DATA_W-1:0] rd_word
);
  assign arready = !rvalid;
  assign ar_fire = arvalid && arready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
      rresp  <= RESP_OKAY;
    end else if (ar_fire) begin
      rvalid <= 1'b1;
      rresp  <= ar_resp;
      rdata  <= (ar_resp == RESP_OKAY) ? rd_word : '0;
    end else if (rready) begin
      rvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/ctrl_reg_lite.sv
module ctrl_reg_lite
  import creg_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int STRB_W  = DATA_W / 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp
);
  // named events for the checker
  logic              aw_hs, w_hs, ar_hs, wr_commit, wr_apply;
  logic [ADDR_W-1:0] cm_addr;
  logic [DATA_W-1:0] cm_data, rd_word;
  logic [STRB_W-1:0] cm_strb;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  resp_e             wr_resp, rd_resp, bresp_e, rresp_e;

  creg_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_wdec (
    .addr(cm_addr), .idx(wr_idx), .resp(wr_resp)
  );

  creg_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_rdec (
    .addr(araddr), .idx(rd_idx), .resp(rd_resp)
  );

  creg_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .bvalid(bvalid), .bready(bready), .bresp(bresp_e),
    .aw_fire(aw_hs), .w_fire(w_hs), .commit(wr_commit),
    .cm_addr(cm_addr), .cm_data(cm_data), .cm_strb(cm_strb),
    .cm_resp(wr_resp)
  );

  assign wr_apply = wr_commit && (wr_resp == RESP_OKAY);

  creg_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_apply), .wr_idx(wr_idx), .wr_data(cm_data), .wr_strb(cm_strb),
    .rd_idx(rd_idx), .rd_data(rd_word)
  );

  creg_rd_ctrl #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .arvalid(arvalid), .arready(arready),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp_e),
    .ar_fire(ar_hs), .ar_resp(rd_resp), .rd_word(rd_word)
  );

  assign bresp = bresp_e;
  assign rresp = rresp_e;
endmodule

// File: rtl/creg_checks.sv
module creg_checks #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              awvalid,
  input logic              awready,
  input logic              wvalid,
  input logic              wready,
  input logic              bvalid,
  input logic              bready,
  input logic [1:0]        bresp,
  input logic              arvalid,
  input logic              arready,
  input logic              rvalid,
  input logic              rready,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        rresp
);
  // handshakes seen since the last write response was taken
  logic seen_aw, seen_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_aw <= 1'b0;
      seen_w  <= 1'b0;
    end else if (bvalid && bready) begin
      seen_aw <= 1'b0;
      seen_w  <= 1'b0;
    end else begin
      if (awvalid && awready) seen_aw <= 1'b1;
      if (wvalid && wready)   seen_w  <= 1'b1;
    end
  end

  p_b_after_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bvalid) |-> ($past(seen_aw || (awvalid && awready)) &&
                       $past(seen_w || (wvalid && wready))));

  p_b_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> (bvalid && $stable(bresp)));

  p_wr_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (!awready && !wready));

  p_r_after_ar_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> $past(arvalid && arready));

  p_r_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rresp)));

  p_ar_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> !arready);

  p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && rresp[1]) |-> (rdata == '0));

  p_no_exokay_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid |-> bresp != 2'b01) and (rvalid |-> rresp != 2'b01));
endmodule

bind ctrl_reg_lite creg_checks #(.DATA_W(DATA_W)) u_checks (
  .clk(clk), .rst_n(rst_n),
  .awvalid(awvalid), .awready(awready),
  .wvalid(wvalid), .wready(wready),
  .bvalid(bvalid), .bready(bready), .bresp(bresp),
  .arvalid(arvalid), .arready(arready),
  .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp)
);

// File: tb/ctrl_reg_lite_test.sv
`timescale 1ns/1ps
module ctrl_reg_lite_test;
  localparam int NREG = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [7:0]  awaddr = 0, araddr = 0;
  logic [31:0] wdata = 0;
  logic [3:0]  wstrb = 0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [1:0]  got_bresp, got_rresp;
  logic [31:0] got_rdata;

  always #10 clk = ~clk;

  ctrl_reg_lite uut (
    .clk(clk), .rst_n(rst_n),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .araddr(araddr),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0]  q_aw[$];
  logic [31:0] q_wd[$];
  logic [3:0]  q_ws[$];
  logic [31:0] m_reg [NREG];
  bit          m_b, m_r;
  logic [1:0]  m_bresp, m_rresp;
  logic [31:0] m_rdata;

  function automatic logic [1:0] code_of(input int a);
    if (a >= NREG * 4) return 2'b11;
    if (a % 4 != 0)    return 2'b10;
    return 2'b00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q_aw.delete(); q_wd.delete(); q_ws.delete();
      m_b = 0; m_r = 0; m_bresp = 0; m_rresp = 0; m_rdata = 0;
      for (int i = 0; i < NREG; i++) m_reg[i] = 0;
    end else begin
      bit take_aw, take_w, take_ar;
      take_aw = awvalid && q_aw.size() == 0 && !m_b;
      take_w  = wvalid && q_wd.size() == 0 && !m_b;
      take_ar = arvalid && !m_r;
      if (take_ar) begin
        m_r = 1;
        m_rresp = code_of(int'(araddr));
        m_rdata = (m_rresp == 2'b00) ? m_reg[araddr / 4] : 32'h0;
      end else if (m_r && rready) begin
        m_r = 0;
      end
      if (take_aw) q_aw.push_back(awaddr);
      if (take_w) begin q_wd.push_back(wdata); q_ws.push_back(wstrb); end
      if (m_b && bready) begin
        m_b = 0;
      end else if (!m_b && q_aw.size() > 0 && q_wd.size() > 0) begin
        int a; logic [31:0] d; logic [3:0] s;
        a = int'(q_aw.pop_front()); d = q_wd.pop_front(); s = q_ws.pop_front();
        m_bresp = code_of(a);
        if (m_bresp == 2'b00)
          for (int b = 0; b < 4; b++)
            if (s[b]) m_reg[a / 4][8*b +: 8] = d[8*b +: 8];
        m_b = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 awready", awready, (q_aw.size() == 0 && !m_b));
      chk("R6 wready", wready, (q_wd.size() == 0 && !m_b));
      chk("R8 arready", arready, !m_r);
      chk("R4 bvalid", bvalid, m_b);
      if (m_b) chk("R5 bresp", bresp, m_bresp);
      chk("R7 rvalid", rvalid, m_r);
      if (m_r) begin
        chk("R7 rdata", rdata, m_rdata);
        chk("R7 rresp", rresp, m_rresp);
      end
    end
  end

  // ---------------- channel drivers ----------------
  task automatic send_aw(input logic [7:0] a, input int dly);
    bit hs;
    repeat (dly) @(negedge clk);
    awaddr = a; awvalid = 1;
    do begin hs = awready; @(negedge clk); end while (!hs);
    awvalid = 0;
  endtask

  task automatic send_w(input logic [31:0] d, input logic [3:0] s, input int dly);
    bit hs;
    repeat (dly) @(negedge clk);
    wdata = d; wstrb = s; wvalid = 1;
    do begin hs = wready; @(negedge clk); end while (!hs);
    wvalid = 0;
  endtask

  task automatic get_b(input int dly);
    while (!bvalid) @(negedge clk);
    chk("R6 readies low", {awready, wready}, 2'b00);
    repeat (dly) begin
      chk("R5 bvalid held", bvalid, 1);
      @(negedge clk);
    end
    bready = 1;
    got_bresp = bresp;
    chk("R11 bresp", (bresp == 2'b01), 0);
    @(negedge clk);
    bready = 0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int order, input int bdly);
    int da, dw;
    da = (order == 0) ? 0 : (order == 1) ? 2 : 0;
    dw = (order == 0) ? 2 : 0;
    fork
      send_aw(a, da);
      send_w(d, s, dw);
    join
    get_b(bdly);
  endtask

  task automatic do_read(input logic [7:0] a, input int rdly);
    bit hs;
    araddr = a; arvalid = 1;
    do begin hs = arready; @(negedge clk); end while (!hs);
    arvalid = 0;
    while (!rvalid) @(negedge clk);
    repeat (rdly) begin
      chk("R8 rvalid held", rvalid, 1);
      @(negedge clk);
    end
    rready = 1;
    got_rdata = rdata; got_rresp = rresp;
    chk("R11 rresp", (rresp == 2'b01), 0);
    @(negedge clk);
    rready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 readies", {awready, wready, arready}, 3'b111);
    chk("R1 valids", {bvalid, rvalid}, 2'b00);
    do_read(8'h0C, 0);
    chk("R1 reg zero", got_rdata, 32'h0);

    // R2 three orderings
    do_write(8'h00, 32'h11223344, 4'hF, 2, 0);
    chk("R2 same-cycle bresp", got_bresp, 2'b00);
    do_read(8'h00, 0);
    chk("R7 read reg0", got_rdata, 32'h11223344);
    chk("R7 rresp okay", got_rresp, 2'b00);
    do_write(8'h04, 32'hDEADBEEF, 4'hF, 0, 1);
    chk("R2 addr-first bresp", got_bresp, 2'b00);
    do_read(8'h04, 0);
    chk("R2 addr-first data", got_rdata, 32'hDEADBEEF);
    do_write(8'h08, 32'hCAFEF00D, 4'hF, 1, 4);
    chk("R2 data-first bresp", got_bresp, 2'b00);
    do_read(8'h08, 3);
    chk("R8 held read data", got_rdata, 32'hCAFEF00D);

    // R3 strobes
    do_write(8'h04, 32'h55667788, 4'b0101, 2, 0);
    do_read(8'h04, 0);
    chk("R3 lanes 0,2", got_rdata, 32'hDE66BE88);
    do_write(8'h04, 32'hFFFFFFFF, 4'b0000, 0, 0);
    do_read(8'h04, 0);
    chk("R3 zero strobe", got_rdata, 32'hDE66BE88);
    do_write(8'h04, 32'hAB000000, 4'b1000, 1, 0);
    do_read(8'h04, 0);
    chk("R3 lane 3", got_rdata, 32'hAB66BE88);

    // R9 out of window
    do_write(8'h20, 32'hFFFFFFFF, 4'hF, 2, 0);
    chk("R9 write decerr", got_bresp, 2'b11);
    do_write(8'hFC, 32'hFFFFFFFF, 4'hF, 0, 2);
    chk("R9 top decerr", got_bresp, 2'b11);
    do_read(8'h00, 0);
    chk("R9 reg0 untouched", got_rdata, 32'h11223344);
    do_read(8'h20, 0);
    chk("R9 read decerr", got_rresp, 2'b11);
    chk("R9 read zero", got_rdata, 32'h0);

    // R10 misaligned
    do_write(8'h06, 32'h00000000, 4'hF, 1, 0);
    chk("R10 write slverr", got_bresp, 2'b10);
    do_read(8'h04, 0);
    chk("R10 reg1 untouched", got_rdata, 32'hAB66BE88);
    do_read(8'h09, 1);
    chk("R10 read slverr", got_rresp, 2'b10);
    chk("R10 read zero", got_rdata, 32'h0);

    // concurrent read and write on the same register
    fork
      do_write(8'h0C, 32'h0F0F0F0F, 4'hF, 2, 1);
      do_read(8'h0C, 1);
    join
    do_read(8'h0C, 0);
    chk("R7 after overlap", got_rdata, 32'h0F0F0F0F);

    // mixed traffic, checked cycle by cycle against the model
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a;
      a = 8'($urandom % 40);
      fork
        do_write(a, $urandom, 4'($urandom % 16), int'($urandom % 3), int'($urandom % 3));
        do_read(8'($urandom % 40), int'($urandom % 3));
      join
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule